// File: doc/BRIEF.md
# Register-Mapped Word FIFO with Interrupt Flags

This block is a single 32-bit synchronous FIFO whose depth is a parameter (256 or 128 words in practice). The push side can be fed either by writes to a data register on a simple register port or by one of two auxiliary engine streams. The pop side can be drained either by reads of that data register or by a dedicated drain port. A per-instance byte lane in a shared control word selects the feeder, the drainer and which of two interrupt lines each side raises. The lane's position inside the 32-bit word is set by a parameter.

The block keeps the fill level and the free space. It latches overflow, underflow, threshold-crossing and sleep-entry events in sticky status flags, which software clears by writing ones. Separate push-side and pop-side configuration registers hold the interrupt enables, a 9-bit word threshold and a sleep request. The memory power state is only reported, as a 2-bit code.

Top module: `pktq_regfifo`

## Requirements
- R1: After reset, every register reads zero except the count word: its free field [24:16] reads DEPTH and its empty bit 15 reads 1. Both interrupt lines and the drain output are 0.
- R2: Lane bit 0 enables the FIFO. While it is 0, no requester can push or pop, and no overflow or underflow is flagged. Writing zero to the lane returns it to disabled with the host routed on both sides.
- R3: Word order is first-in first-out. With the host routed, a write to address 5 pushes one word and a read of address 5 pops one word. That read returns the head word, or 0 when the FIFO is empty or the host is not the drainer.
- R4: Lane bit 1 set makes an engine the feeder; lane bit 5 then picks engine 1 over engine 0. Pushes from the engine not picked, and host data writes, are ignored. A push and a pop in the same cycle are both taken.
- R5: Lane bit 2 set makes the drain port the drainer. A drain_pop pops the word shown on drn_rdata, which is the head, or 0 when empty. Host data reads then return 0 and do not pop.
- R6: The count word at address 4 holds the fill level in [8:0], the free space in [24:16], empty in bit 15 and full in bit 31. Fill plus free equals DEPTH.
- R7: A push to a full FIFO is dropped, leaves the contents unchanged and sets status bit 2 (overflow).
- R8: A pop from an empty FIFO returns 0, leaves the FIFO empty and sets status bit 5 (underflow).
- R9: Status bit 3 sets one cycle after free space becomes less than or equal to the push threshold (push config [24:16]). It sets once per crossing.
- R10: Status bit 6 sets one cycle after the fill level becomes greater than or equal to the pop threshold (pop config [24:16]). It sets once per crossing. A condition already true when reset is released does not count as a crossing.
- R11: Writing 1 to a status flag bit at address 1 clears it, and writing 0 leaves it. A flag that is set and cleared in the same cycle stays set.
- R12: The push-side interrupt is the OR of status bits 2, 3 and 4, each gated by push config bits 2, 3 and 4. The pop-side interrupt is the OR of status bits 5, 6 and 7, gated by pop config bits 2, 3 and 4. Lane bit 3 (push side) and lane bit 4 (pop side) route each one to irq_aux when set and to irq_host when clear.
- R13: The status sleep code [1:0] is 0 (active) when no sleep is requested. It is 1 (light) when only push config bit 0 is set. When pop config bit 0 is set it is 2 (deep), or 3 (shutdown) if pop config bit 1 is also set. A write that raises push config bit 0 sets status bit 4, and one that raises pop config bit 0 sets status bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops only at address 5) |
| bus_addr | input | 3 | Register word address: 0 lane, 1 status, 2 push config, 3 pop config, 4 count, 5 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| eng_push | input | 2 | Push strobes of engine 0 and engine 1 |
| eng_data0 | input | 32 | Engine 0 push word |
| eng_data1 | input | 32 | Engine 1 push word |
| drn_pop | input | 1 | Drain port pop strobe |
| drn_rdata | output | 32 | Head word for the drain port, 0 when empty |
| irq_host | output | 1 | Interrupt line to the host |
| irq_aux | output | 1 | Interrupt line to the auxiliary processor |

## Verification
Every push, pop, register write and flag event is taken at the rising edge where its strobe is sampled. Its effect shows at the ports right after that edge. The exception is the two threshold flags, which appear one edge later because they are detected from the registered counts. Register reads are combinational, so a popping read returns the head before the edge that removes it. The bench holds each stimulus for exactly one cycle and compares all outputs against a queue-based model shortly after the falling edge, so each result is observed in the cycle it is due.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
  localparam int DW = 32;
  localparam int TW = 9;

  localparam logic [2:0] A_LANE = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_PSHC = 3'd2;
  localparam logic [2:0] A_POPC = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;

  typedef struct packed {
    logic alt_sel;
    logic pop_irq_aux;
    logic push_irq_aux;
    logic pop_to_drain;
    logic push_from_eng;
    logic en;
  } lane_t;

  typedef struct packed {
    logic [TW-1:0] thr;
    logic          slp_irq_en;
    logic          thr_irq_en;
    logic          xf_irq_en;
    logic          slp_type;
    logic          slp_en;
  } side_cfg_t;

  function automatic side_cfg_t side_unpack(input logic [DW-1:0] w);
    return side_cfg_t'({w[24:16], w[4:0]});
  endfunction

  function automatic logic [DW-1:0] side_pack(input side_cfg_t c);
    return {7'b0, c.thr, 11'b0, c.slp_irq_en, c.thr_irq_en, c.xf_irq_en, c.slp_type, c.slp_en};
  endfunction

  function automatic logic [DW-1:0] count_pack(input logic [TW-1:0] fill, input logic [TW-1:0] free,
                                               input logic emp, input logic ful);
    return {ful, 6'b0, free, emp, 6'b0, fill};
  endfunction

  function automatic logic [1:0] sleep_code(input side_cfg_t push_c, input side_cfg_t pop_c);
    if (pop_c.slp_en)  return pop_c.slp_type ? 2'd3 : 2'd2;
    if (push_c.slp_en) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic push_hit(input logic [TW-1:0] free, input logic [TW-1:0] thr);
    return free <= thr;
  endfunction

  function automatic logic pop_hit(input logic [TW-1:0] fill, input logic [TW-1:0] thr);
    return fill >= thr;
  endfunction
endpackage

// File: rtl/pktq_store.sv
module pktq_store #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [31:0]   push_data,
  input  logic          pop_req,
  output logic [31:0]   head,
  output logic [CW-1:0] fill,
  output logic          empty,
  output logic          full,
  output logic          push_drop,
  output logic          pop_miss
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (fill == CW'(DEPTH));
  assign empty     = (fill == '0);
  assign do_push   = push_req & ~full;
  assign do_pop    = pop_req & ~empty;
  assign push_drop = push_req & full;
  assign pop_miss  = pop_req & empty;
  assign head      = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_DROP_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_req) |=> $stable(fill)); // R7
  AST_MISS_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_miss && !push_req) |=> empty); // R8
endmodule

// File: rtl/pktq_flags.sv
module pktq_flags
  import pktq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf_evt,
  input  logic          unf_evt,
  input  logic [TW-1:0] fill9,
  input  logic [TW-1:0] free9,
  input  side_cfg_t     push_cfg,
  input  side_cfg_t     pop_cfg,
  input  logic          push_slp_rise,
  input  logic          pop_slp_rise,
  input  logic [5:0]    clr_mask,
  output logic [5:0]    flags,
  output logic          push_irq,
  output logic          pop_irq
);
  logic       pthr_now, qthr_now, pthr_prev, qthr_prev;
  logic [5:0] set_vec;

  assign pthr_now = push_hit(free9, push_cfg.thr);
  assign qthr_now = pop_hit(fill9, pop_cfg.thr);

  always_comb begin
    set_vec    = '0;
    set_vec[0] = ovf_evt;
    set_vec[1] = pthr_now & ~pthr_prev;
    set_vec[2] = push_slp_rise;
    set_vec[3] = unf_evt;
    set_vec[4] = qthr_now & ~qthr_prev;
    set_vec[5] = pop_slp_rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '0;
      pthr_prev <= 1'b1;
      qthr_prev <= 1'b1;
    end else begin
      flags     <= (flags & ~clr_mask) | set_vec;
      pthr_prev <= pthr_now;
      qthr_prev <= qthr_now;
    end
  end

  assign push_irq = |(flags[2:0] & {push_cfg.slp_irq_en, push_cfg.thr_irq_en, push_cfg.xf_irq_en});
  assign pop_irq  = |(flags[5:3] & {pop_cfg.slp_irq_en, pop_cfg.thr_irq_en, pop_cfg.xf_irq_en});

  AST_OVF_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[0]); // R7
  AST_UNF_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> flags[3]); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && clr_mask[0]) |=> flags[0]); // R11
endmodule

// File: rtl/pktq_csr.sv
module pktq_csr
  import pktq_pkg::*;
#(
  parameter int LANE = 0,
  localparam int LO = LANE * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [5:0]    flags,
  input  logic [TW-1:0] fill9,
  input  logic [TW-1:0] free9,
  input  logic          empty,
  input  logic          full,
  input  logic [31:0]   data_view,
  output lane_t         lane,
  output side_cfg_t     push_cfg,
  output side_cfg_t     pop_cfg,
  output logic [5:0]    clr_mask,
  output logic          push_slp_rise,
  output logic          pop_slp_rise
);
  logic [7:0] lane_wd;
  logic       wr_lane, wr_pshc, wr_popc, wr_stat;

  assign lane_wd = bus_wdata[LO +: 8];
  assign wr_lane = bus_wr && (bus_addr == A_LANE);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_pshc = bus_wr && (bus_addr == A_PSHC);
  assign wr_popc = bus_wr && (bus_addr == A_POPC);

  assign clr_mask      = wr_stat ? lane_wd[7:2] : 6'b0;
  assign push_slp_rise = wr_pshc && bus_wdata[0] && !push_cfg.slp_en;
  assign pop_slp_rise  = wr_popc && bus_wdata[0] && !pop_cfg.slp_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane     <= '0;
      push_cfg <= '0;
      pop_cfg  <= '0;
    end else begin
      if (wr_lane) lane     <= lane_t'(lane_wd[5:0]);
      if (wr_pshc) push_cfg <= side_unpack(bus_wdata);
      if (wr_popc) pop_cfg  <= side_unpack(bus_wdata);
    end
  end

  always_comb begin
    case (bus_addr)
      A_LANE:  bus_rdata = 32'({2'b0, lane}) << LO;
      A_STAT:  bus_rdata = 32'({flags, sleep_code(push_cfg, pop_cfg)}) << LO;
      A_PSHC:  bus_rdata = side_pack(push_cfg);
      A_POPC:  bus_rdata = side_pack(pop_cfg);
      A_CNT:   bus_rdata = count_pack(fill9, free9, empty, full);
      A_DATA:  bus_rdata = data_view;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pktq_regfifo.sv
module pktq_regfifo
  import pktq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LANE  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  eng_push,
  input  logic [31:0] eng_data0,
  input  logic [31:0] eng_data1,
  input  logic        drn_pop,
  output logic [31:0] drn_rdata,
  output logic        irq_host,
  output logic        irq_aux
);
  localparam int CW = $clog2(DEPTH + 1);

  lane_t         lane;
  side_cfg_t     push_cfg, pop_cfg;
  logic [5:0]    flags, clr_mask;
  logic          push_slp_rise, pop_slp_rise;
  logic          host_wr_data, host_rd_data;
  logic          push_req, pop_req, eng_sel_push;
  logic [31:0]   push_word, eng_sel_word, head, data_view;
  logic [CW-1:0] fill;
  logic [TW-1:0] fill9, free9;
  logic          empty, full, ovf_evt, unf_evt, push_irq, pop_irq;

  assign host_wr_data = bus_wr && (bus_addr == A_DATA);
  assign host_rd_data = bus_rd && (bus_addr == A_DATA);

  assign eng_sel_push = lane.alt_sel ? eng_push[1] : eng_push[0];
  assign eng_sel_word = lane.alt_sel ? eng_data1 : eng_data0;
  assign push_req  = lane.en && (lane.push_from_eng ? eng_sel_push : host_wr_data);
  assign push_word = lane.push_from_eng ? eng_sel_word : bus_wdata;
  assign pop_req   = lane.en && (lane.pop_to_drain ? drn_pop : host_rd_data);

  assign fill9 = TW'(fill);
  assign free9 = TW'(DEPTH) - fill9;

  assign drn_rdata = empty ? '0 : head;
  assign data_view = (lane.en && !lane.pop_to_drain && !empty) ? head : '0;

  pktq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_data(push_word), .pop_req(pop_req),
    .head(head), .fill(fill), .empty(empty), .full(full),
    .push_drop(ovf_evt), .pop_miss(unf_evt)
  );

  pktq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .fill9(fill9), .free9(free9),
    .push_cfg(push_cfg), .pop_cfg(pop_cfg),
    .push_slp_rise(push_slp_rise), .pop_slp_rise(pop_slp_rise),
    .clr_mask(clr_mask), .flags(flags),
    .push_irq(push_irq), .pop_irq(pop_irq)
  );

  pktq_csr #(.LANE(LANE)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flags(flags), .fill9(fill9), .free9(free9), .empty(empty), .full(full),
    .data_view(data_view), .lane(lane), .push_cfg(push_cfg), .pop_cfg(pop_cfg),
    .clr_mask(clr_mask), .push_slp_rise(push_slp_rise), .pop_slp_rise(pop_slp_rise)
  );

  assign irq_host = (push_irq && !lane.push_irq_aux) || (pop_irq && !lane.pop_irq_aux);
  assign irq_aux  = (push_irq && lane.push_irq_aux) || (pop_irq && lane.pop_irq_aux);

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !lane.en |=> $stable(fill)); // R2
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 6'b0) |-> (!irq_host && !irq_aux)); // R12
  AST_DRAIN_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> (drn_rdata == 32'd0)); // R5
endmodule

// File: tb/pktq_regfifo_tb.sv
module pktq_regfifo_tb;
  localparam int DEPTH = 256;
  localparam int LANE  = 1;
  localparam int LS    = LANE * 8;
  localparam logic [31:0] CFG_MASK = 32'h01FF_001F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0, eng_data0 = '0, eng_data1 = '0;
  logic [1:0]  eng_push = '0;
  logic        drn_pop = 1'b0;
  logic [31:0] bus_rdata, drn_rdata;
  logic        irq_host, irq_aux;

  always #5 clk = ~clk;

  pktq_regfifo #(.DEPTH(DEPTH), .LANE(LANE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_push(eng_push),
    .eng_data0(eng_data0), .eng_data1(eng_data1), .drn_pop(drn_pop),
    .drn_rdata(drn_rdata), .irq_host(irq_host), .irq_aux(irq_aux)
  );

  // reference model state
  int unsigned q[$];
  logic [7:0]  m_lane = '0;
  logic [31:0] m_pshc = '0, m_popc = '0;
  logic [5:0]  m_fl = '0;
  bit          m_pprev = 1'b1, m_qprev = 1'b1;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  function automatic logic [1:0] m_sleep();
    if (m_popc[0]) return m_popc[1] ? 2'd3 : 2'd2;
    return m_pshc[0] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [31:0] m_rdata(input logic [2:0] a);
    int f;
    f = q.size();
    case (a)
      3'd0: return 32'(m_lane) << LS;
      3'd1: return 32'({m_fl, m_sleep()}) << LS;
      3'd2: return m_pshc;
      3'd3: return m_popc;
      3'd4: return {(f == DEPTH), 6'b0, 9'(DEPTH - f), (f == 0), 6'b0, 9'(f)};
      3'd5: return (m_lane[0] && !m_lane[2] && f > 0) ? q[0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit en, preq, qreq, ful, emp, pc, qc;
    logic [31:0] pdat;
    logic [5:0] setv, clr;
    en   = m_lane[0];
    preq = en && (m_lane[1] ? (m_lane[5] ? eng_push[1] : eng_push[0]) : (bus_wr && bus_addr == 3'd5));
    pdat = m_lane[1] ? (m_lane[5] ? eng_data1 : eng_data0) : bus_wdata;
    qreq = en && (m_lane[2] ? drn_pop : (bus_rd && bus_addr == 3'd5));
    ful  = (q.size() == DEPTH);
    emp  = (q.size() == 0);
    pc   = (DEPTH - q.size()) <= int'(m_pshc[24:16]);
    qc   = q.size() >= int'(m_popc[24:16]);
    setv = '0;
    setv[0] = preq && ful;
    setv[3] = qreq && emp;
    setv[1] = pc && !m_pprev;
    setv[4] = qc && !m_qprev;
    setv[2] = bus_wr && bus_addr == 3'd2 && bus_wdata[0] && !m_pshc[0];
    setv[5] = bus_wr && bus_addr == 3'd3 && bus_wdata[0] && !m_popc[0];
    m_pprev = pc;
    m_qprev = qc;
    clr  = (bus_wr && bus_addr == 3'd1) ? bus_wdata[LS+2 +: 6] : 6'b0;
    m_fl = (m_fl & ~clr) | setv;
    if (bus_wr && bus_addr == 3'd0) m_lane = bus_wdata[LS +: 8] & 8'h3F;
    if (bus_wr && bus_addr == 3'd2) m_pshc = bus_wdata & CFG_MASK;
    if (bus_wr && bus_addr == 3'd3) m_popc = bus_wdata & CFG_MASK;
    if (qreq && !emp) void'(q.pop_front());
    if (preq && !ful) q.push_back(pdat);
  endtask

  // one clock: compare against model before the edge, advance model at the edge
  task automatic step();
    bit ph, qh;
    #1;
    ph = (m_fl[0] & m_pshc[2]) | (m_fl[1] & m_pshc[3]) | (m_fl[2] & m_pshc[4]);
    qh = (m_fl[3] & m_popc[2]) | (m_fl[4] & m_popc[3]) | (m_fl[5] & m_popc[4]);
    cmp("bus_rdata", bus_rdata, m_rdata(bus_addr));
    cmp("drn_rdata", drn_rdata, (q.size() > 0) ? q[0] : 32'd0);
    cmp("irq_host", 32'(irq_host), 32'((ph && !m_lane[3]) || (qh && !m_lane[4])));
    cmp("irq_aux", 32'(irq_aux), 32'((ph && m_lane[3]) || (qh && m_lane[4])));
    @(posedge clk);
    model_update();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = 3'd0; bus_wdata = '0;
    eng_push = '0; drn_pop = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step();
  endtask
  task automatic rd(input logic [2:0] a);
    bus_rd = 1; bus_addr = a; step();
  endtask
  task automatic drain();
    drn_pop = 1; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values of every register and output
    cur_req = "R1";
    for (int a = 0; a < 6; a++) rd(3'(a));
    // R2: disabled lane ignores pushes and pops
    cur_req = "R2";
    wr(3'd5, 32'hAAAA_0001);
    drain();
    rd(3'd5);
    rd(3'd4);
    rd(3'd1);
    // R3: host push and pop in order
    cur_req = "R3";
    wr(3'd0, 32'h01 << LS);
    for (int i = 0; i < 5; i++) wr(3'd5, 32'h1000 + i);
    for (int i = 0; i < 3; i++) rd(3'd5);
    // R6: count fields after partial fill
    cur_req = "R6";
    rd(3'd4);
    // R9, R10: thresholds with their irq enables
    cur_req = "R9";
    wr(3'd2, (32'd4 << 16) | 32'h0C);
    cur_req = "R10";
    wr(3'd3, (32'd8 << 16) | 32'h08);
    for (int i = 0; i < DEPTH - 2; i++) wr(3'd5, 32'h2000 + i);
    rd(3'd1);
    // R7: push while full
    cur_req = "R7";
    wr(3'd5, 32'hDEAD_BEEF);
    rd(3'd1);
    rd(3'd4);
    // R11: clear by writing one, set wins over clear
    cur_req = "R11";
    wr(3'd1, 32'h04 << LS);
    rd(3'd1);
    wr(3'd0, 32'h03 << LS);
    bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'h04 << LS;
    eng_push = 2'b01; eng_data0 = 32'h5555; step();
    rd(3'd1);
    wr(3'd1, 32'h00 << LS);
    rd(3'd1);
    wr(3'd1, 32'hFC << LS);
    rd(3'd1);
    // R4: engine 1 feeds, drain drains, simultaneous push and pop
    cur_req = "R4";
    wr(3'd0, (32'h01 | 32'h02 | 32'h04 | 32'h20) << LS);
    for (int i = 0; i < 3; i++) drain();
    eng_push = 2'b01; eng_data0 = 32'h0E00; step();
    eng_push = 2'b10; eng_data1 = 32'h0E11; step();
    wr(3'd5, 32'h0BAD);
    eng_push = 2'b10; eng_data1 = 32'h0E22; drn_pop = 1; step();
    rd(3'd4);
    // R5: drain port owns the pop side
    cur_req = "R5";
    rd(3'd5);
    rd(3'd4);
    while (q.size() > 0) drain();
    // R8: pop when empty
    cur_req = "R8";
    drain();
    rd(3'd1);
    rd(3'd4);
    // R12: interrupt routing
    cur_req = "R12";
    wr(3'd3, 32'h04);
    wr(3'd0, (32'h01 | 32'h04 | 32'h10) << LS);
    wr(3'd2, 32'h04);
    wr(3'd0, (32'h01 | 32'h08) << LS);
    wr(3'd1, 32'hFC << LS);
    step();
    // R13: sleep code and sleep flags
    cur_req = "R13";
    wr(3'd2, 32'h11);
    rd(3'd1);
    wr(3'd3, 32'h03);
    rd(3'd1);
    wr(3'd3, 32'h01);
    rd(3'd1);
    wr(3'd2, 32'h00);
    rd(3'd1);
    // R2: clearing the lane disables and restores default routing
    cur_req = "R2";
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h7777);
    rd(3'd4);
    rd(3'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule